// File: doc/BRIEF.md
# Pin Pattern Interrupt Engine

The engine watches a small group of input pins and raises an interrupt when a programmable Boolean sum-of-products over those pins becomes true. Every pin passes through a two-flop synchronizer. The synchronized sample is then compared with the sample from the previous clock to detect rising and falling edges. A row of slices tests the pins. Each slice picks one input and one condition: a level, an edge, always true, or never true. Consecutive slices are ANDed into a product term. A per-slice end-of-term bit closes the current term. The closed terms are ORed into a registered match interrupt. The engine evaluates the expression on every clock, so the interrupt is asserted for as long as any term holds.

A mode input selects a second function that uses the same synchronized pins: a plain per-pin interrupt. In this mode each pin is either edge sensitive, with a sticky flag that is cleared by a write-one pulse, or level sensitive, where the output follows the pin. Only one of the two functions drives its outputs at a time. All configuration is supplied on static input vectors by the surrounding logic.

Top module: `pin_pattern_irq`

## Requirements
- R1: A pin change that is present at rising edge k is reflected in `match_irq_o` and `pin_irq_o` after rising edge k+2. The earlier edges show no effect of that change.
- R2: Slice condition codes are 0 always true, 1 input high, 2 input low, 3 rising edge, 4 falling edge, 5 either edge, and 6 or 7 never true.
- R3: An edge is detected by comparing the current synchronized sample with the previous one. An edge condition is therefore true for exactly one clock per pin transition, including while the pin then stays at its new level.
- R4: Slices are ANDed in index order into a product term. A slice whose end-of-term bit is 1 closes the term, and the next slice starts a new one. Slices above the last end-of-term bit take part in no term.
- R5: While `mode_match_i` is 1, `match_irq_o` is 1 exactly when at least one closed term is true. It is re-evaluated on every clock.
- R6: While `mode_match_i` is 0, `match_irq_o` is 0. While it is 1, `pin_irq_o` is all zeros and every sticky flag is discarded.
- R7: In pin mode with the level bit 0, `pin_irq_o[i]` is set by a rising edge when `pin_cfg_a_i[i]` is 1 and by a falling edge when `pin_cfg_b_i[i]` is 1. It then stays set until `pin_clr_i[i]` is 1 at a clock edge.
- R8: If a clear pulse and a new enabled edge on the same pin fall on the same clock, the flag is set.
- R9: In pin mode with the level bit 1, `pin_irq_o[i]` equals (a and pin high) or (b and pin low), and `pin_clr_i[i]` has no effect.
- R10: The select field of slice s is `slice_sel_i[s*SEL_W +: SEL_W]`, and it picks the input index that the slice tests.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N_IN | Asynchronous pin inputs |
| mode_match_i | input | 1 | 1 selects the pattern function, 0 selects the per-pin function |
| slice_sel_i | input | N_SLICE*SEL_W | Input index for each slice |
| slice_cond_i | input | N_SLICE*3 | Condition code for each slice |
| slice_eot_i | input | N_SLICE | End-of-term bit for each slice |
| pin_level_i | input | N_IN | Per pin: 1 for level sensitive, 0 for edge sensitive |
| pin_cfg_a_i | input | N_IN | Per pin: rising-edge enable, or active-high enable in level mode |
| pin_cfg_b_i | input | N_IN | Per pin: falling-edge enable, or active-low enable in level mode |
| pin_clr_i | input | N_IN | Per pin: write-one clear of the sticky edge flag |
| match_irq_o | output | 1 | Pattern match interrupt |
| pin_irq_o | output | N_IN | Per-pin interrupts |

## Verification
Two events in the per-pin function can fall on the same clock for one pin: a clear of the sticky flag and a fresh enabled edge. The bench provokes this by holding the clear bit of a pin high for many cycles while that pin toggles, and also by driving dense random clear pulses against random pin activity. A behavioural model keeps a history of the pin samples and checks, every cycle, that the flag ends up set whenever an edge coincides with a clear. The same model also covers mode switches that fall on cycles when flags are pending.

// File: rtl/pme_pkg.sv
package pme_pkg;

  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    COND_ONE   = 3'd0,
    COND_HIGH  = 3'd1,
    COND_LOW   = 3'd2,
    COND_RISE  = 3'd3,
    COND_FALL  = 3'd4,
    COND_EDGE  = 3'd5,
    COND_NONE6 = 3'd6,
    COND_NONE7 = 3'd7
  } cond_e;

  function automatic logic cond_eval(input cond_e c, input logic lvl,
                                     input logic rs, input logic fl);
    logic r;
    case (c)
      COND_ONE:  r = 1'b1;
      COND_HIGH: r = lvl;
      COND_LOW:  r = ~lvl;
      COND_RISE: r = rs;
      COND_FALL: r = fl;
      COND_EDGE: r = rs | fl;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign rise_o = cur_q & ~prv_q;
  assign fall_o = ~cur_q & prv_q;

  // R3
  rise_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

  // R3
  fall_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o != '0) |=> ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/pme_slice.sv
module pme_slice
  import pme_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int SEL_W = 3
) (
  input  logic [N_IN-1:0]   cur_i,
  input  logic [N_IN-1:0]   rise_i,
  input  logic [N_IN-1:0]   fall_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              hit_o
);

  logic lvl, rs, fl;

  always_comb begin
    lvl = 1'b0;
    rs  = 1'b0;
    fl  = 1'b0;
    if (int'(sel_i) < N_IN) begin
      lvl = cur_i[sel_i];
      rs  = rise_i[sel_i];
      fl  = fall_i[sel_i];
    end
    hit_o = cond_eval(cond_e'(cond_i), lvl, rs, fl);
  end

endmodule

// File: rtl/pme_chain.sv
module pme_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] hit_i,
  input  logic [N-1:0] eot_i,
  output logic         match_o
);

  logic acc, any;

  // running AND per term, closed terms ORed
  always_comb begin
    acc = 1'b1;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      acc = acc & hit_i[k];
      if (eot_i[k]) begin
        any = any | acc;
        acc = 1'b1;
      end
    end
    match_o = any;
  end

endmodule

// File: rtl/pme_pinint.sv
module pme_pinint #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irq_o
);

  logic [N-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!en_i) begin
          irq_q[i] <= 1'b0;
        end else if (lvl_i[i]) begin
          irq_q[i] <= (a_i[i] & cur_i[i]) | (b_i[i] & ~cur_i[i]);
        end else begin
          // a new edge wins over a clear in the same cycle
          irq_q[i] <= (irq_q[i] & ~clr_i[i]) | (a_i[i] & rise_i[i]) |
                      (b_i[i] & fall_i[i]);
        end
      end
    end
  end

  assign irq_o = irq_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R7
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !lvl_i[g] && irq_o[g] && !clr_i[g]) |=> irq_o[g]);

    // R8
    set_over_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !lvl_i[g] && a_i[g] && rise_i[g]) |=> irq_o[g]);

    // R9
    level_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && lvl_i[g] && !a_i[g] && !b_i[g]) |=> !irq_o[g]);
  end

endmodule

// File: rtl/pin_pattern_irq.sv
module pin_pattern_irq
  import pme_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int N_SLICE = 8,
  parameter int SEL_W   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_IN-1:0]            pin_i,
  input  logic                       mode_match_i,
  input  logic [N_SLICE*SEL_W-1:0]   slice_sel_i,
  input  logic [N_SLICE*COND_W-1:0]  slice_cond_i,
  input  logic [N_SLICE-1:0]         slice_eot_i,
  input  logic [N_IN-1:0]            pin_level_i,
  input  logic [N_IN-1:0]            pin_cfg_a_i,
  input  logic [N_IN-1:0]            pin_cfg_b_i,
  input  logic [N_IN-1:0]            pin_clr_i,
  output logic                       match_irq_o,
  output logic [N_IN-1:0]            pin_irq_o
);

  logic [N_IN-1:0]    cur, rise, fall;
  logic [N_SLICE-1:0] hit;
  logic               match_c;
  logic               match_q;

  pme_sync #(.N(N_IN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .cur_o  (cur),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    pme_slice #(.N_IN(N_IN), .SEL_W(SEL_W)) u_slice (
      .cur_i  (cur),
      .rise_i (rise),
      .fall_i (fall),
      .sel_i  (slice_sel_i[s*SEL_W +: SEL_W]),
      .cond_i (slice_cond_i[s*COND_W +: COND_W]),
      .hit_o  (hit[s])
    );
  end

  pme_chain #(.N(N_SLICE)) u_chain (
    .hit_i   (hit),
    .eot_i   (slice_eot_i),
    .match_o (match_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= mode_match_i & match_c;
  end

  pme_pinint #(.N(N_IN)) u_pinint (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~mode_match_i),
    .cur_i  (cur),
    .rise_i (rise),
    .fall_i (fall),
    .lvl_i  (pin_level_i),
    .a_i    (pin_cfg_a_i),
    .b_i    (pin_cfg_b_i),
    .clr_i  (pin_clr_i),
    .irq_o  (pin_irq_o)
  );

  assign match_irq_o = match_q;

  // R6
  mode_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_irq_o && (|pin_irq_o)));

  // R6
  match_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_match_i |=> !match_irq_o);

  // R6
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_match_i |=> (pin_irq_o == '0));

endmodule

// File: tb/pin_pattern_irq_tb.sv
`timescale 1ns/1ps
module pin_pattern_irq_tb;

  localparam int NI = 8;
  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NI-1:0] pin = '0;
  logic          mode = 1'b1;
  logic [NS*SW-1:0] sel = '0;
  logic [NS*3-1:0]  cond = '0;
  logic [NS-1:0]    eot = '0;
  logic [NI-1:0] lvl = '0, cfa = '0, cfb = '0, clr = '0;
  logic          match_irq;
  logic [NI-1:0] pin_irq;

  int n_cmp = 0, n_bad = 0;
  string req = "R11";
  bit done = 0;

  logic [NI-1:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;
  logic          exp_match = 1'b0;
  logic [NI-1:0] exp_pin = '0;

  always #10 clk = ~clk;

  pin_pattern_irq #(.N_IN(NI), .N_SLICE(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin), .mode_match_i(mode),
    .slice_sel_i(sel), .slice_cond_i(cond), .slice_eot_i(eot),
    .pin_level_i(lvl), .pin_cfg_a_i(cfa), .pin_cfg_b_i(cfb),
    .pin_clr_i(clr), .match_irq_o(match_irq), .pin_irq_o(pin_irq)
  );

  task automatic cmp(string tag, logic [NI-1:0] act, logic [NI-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic cond_of(int code, logic c, logic p);
    case (code)
      0: return 1'b1;
      1: return c;
      2: return !c;
      3: return c && !p;
      4: return !c && p;
      5: return c != p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic model_match();
    logic acc = 1'b1;
    logic m = 1'b0;
    for (int s = 0; s < NS; s++) begin
      int idx = int'(sel[s*SW +: SW]);
      acc = acc & cond_of(int'(cond[s*3 +: 3]), h2[idx], h3[idx]);
      if (eot[s]) begin
        m = m | acc;
        acc = 1'b1;
      end
    end
    return m;
  endfunction

  // one clock: model the edge that just passed, compare, return for new drive
  task automatic step();
    @(negedge clk);
    h3 = h2; h2 = h1; h1 = h0; h0 = pin;
    if (mode) begin
      exp_match = model_match();
      exp_pin = '0;
    end else begin
      exp_match = 1'b0;
      for (int i = 0; i < NI; i++) begin
        if (lvl[i]) exp_pin[i] = (cfa[i] & h2[i]) | (cfb[i] & ~h2[i]);
        else exp_pin[i] = (exp_pin[i] & ~clr[i]) | (cfa[i] & h2[i] & ~h3[i]) |
                          (cfb[i] & ~h2[i] & h3[i]);
      end
    end
    cmp({req, " match"}, {7'd0, match_irq}, {7'd0, exp_match});
    cmp({req, " pin"}, pin_irq, exp_pin);
  endtask

  task automatic set_slice(int s, int sl, int cd, bit e);
    sel[s*SW +: SW] = SW'(sl);
    cond[s*3 +: 3]  = 3'(cd);
    eot[s]          = e;
  endtask

  task automatic clear_slices();
    for (int s = 0; s < NS; s++) set_slice(s, 0, 0, 1'b0);
  endtask

  // slow toggling: each pin flips with probability 1/8
  task automatic slow_pins();
    for (int i = 0; i < NI; i++) if (($urandom % 8) == 0) pin[i] = ~pin[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    pin = '1;
    cmp("R11 match", {7'd0, match_irq}, '0);
    cmp("R11 pin", pin_irq, '0);
    @(negedge clk);
    pin = '0;
    @(negedge clk);
    rst_ni = 1'b1;

    // R1: latency of two extra edges
    req = "R1";
    clear_slices();
    set_slice(0, 2, 1, 1'b1);
    repeat (4) step();
    pin[2] = 1'b1;
    step(); cmp("R1 edge k", {7'd0, match_irq}, '0);
    step(); cmp("R1 edge k+1", {7'd0, match_irq}, '0);
    step(); cmp("R1 edge k+2", {7'd0, match_irq}, 8'd1);
    pin = '0;
    repeat (4) step();

    // R2: every condition code on one slice
    for (int c = 0; c < 8; c++) begin
      req = "R2";
      clear_slices();
      set_slice(0, 5, c, 1'b1);
      repeat (40) begin slow_pins(); step(); end
    end

    // R3: edges last one clock while the pin holds
    req = "R3";
    clear_slices();
    set_slice(0, 1, 3, 1'b1);
    set_slice(1, 1, 4, 1'b1);
    repeat (80) begin slow_pins(); step(); end

    // R10: select field picks the tested input
    for (int s = 0; s < 8; s++) begin
      req = "R10";
      clear_slices();
      set_slice(0, s, 1, 1'b1);
      repeat (20) begin pin = NI'($urandom); step(); end
    end

    // R4: three-term expression, then the last term left open
    req = "R4";
    clear_slices();
    set_slice(0, 0, 1, 1'b0); set_slice(1, 1, 2, 1'b0); set_slice(2, 3, 3, 1'b1);
    set_slice(3, 4, 1, 1'b0); set_slice(4, 5, 1, 1'b1);
    set_slice(5, 0, 1, 1'b0); set_slice(6, 3, 2, 1'b0); set_slice(7, 4, 2, 1'b1);
    repeat (200) begin pin = NI'($urandom); step(); end
    eot[7] = 1'b0;
    repeat (100) begin pin = NI'($urandom); step(); end

    // R5: random expressions held for a few cycles each
    req = "R5";
    repeat (60) begin
      sel = ($urandom); cond = ($urandom); eot = NS'($urandom);
      repeat (8) begin slow_pins(); step(); end
    end

    // R7: sticky edge flags with sparse clears
    req = "R7";
    mode = 1'b0; lvl = '0;
    cfa = NI'($urandom); cfb = NI'($urandom);
    repeat (200) begin
      slow_pins();
      clr = NI'($urandom) & NI'($urandom) & NI'($urandom);
      step();
    end
    clr = '0;

    // R8: clear held high while the pin toggles
    req = "R8";
    cfa = 8'h01; cfb = 8'h00; clr = 8'h01;
    repeat (60) begin
      if (($urandom % 3) == 0) pin[0] = ~pin[0];
      step();
    end
    cfa = '1; cfb = '1;
    repeat (150) begin pin = NI'($urandom); clr = NI'($urandom); step(); end
    clr = '0;

    // R9: level sensitivity ignores clears
    req = "R9";
    lvl = '1;
    repeat (120) begin
      cfa = NI'($urandom); cfb = NI'($urandom);
      pin = NI'($urandom); clr = NI'($urandom);
      step();
    end

    // R6: mode switches with pending flags
    req = "R6";
    lvl = 8'h0f; cfa = '1; cfb = 8'h33; clr = '0;
    set_slice(0, 2, 0, 1'b1);
    repeat (20) begin
      mode = ~mode;
      repeat (7) begin pin = NI'($urandom); step(); end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule